// File: doc/BRIEF.md
# Alignment Traceback Walker

This block recovers an alignment path from a stored matrix of 2-bit traceback pointers. Once given a start cell and one of four alignment strategies, it walks toward the top-left of the matrix. At each interior cell it reads the pointer for that cell from an external memory and turns it into one alignment move: match/mismatch, insertion, deletion or end. Each move is presented on a valid-qualified output. When the walk stops, the block raises a one-cycle done flag and shows the cell where the walk finished.

The strategy decides what happens when the walk meets the matrix border:

- Global walks continue with pure gap moves until they reach cell (0,0).
- Semi-global walks continue with deletions down the left column until they reach row 0.
- Local and overlap walks stop at the first row-0 or column-0 cell.

In every strategy, an END pointer read at an interior cell stops the walk at once. Filling the matrix and choosing the start cell are handled elsewhere.

The controller has four named states:

- `ST_IDLE` waits for a start pulse. A start pulse moves it to `ST_LOOK`.
- `ST_LOOK` examines the current cell:
  - At an interior cell it issues a pointer read and moves to `ST_MM`.
  - At a border cell that needs a gap, it emits that gap move and stays in `ST_LOOK`.
  - When the border rule says stop, it moves to `ST_DONE`.
- `ST_MM` consumes the returned pointer one cycle after the read and emits the move. A DIAG, UP or LEFT pointer returns it to `ST_LOOK`. An END or any other code takes it to `ST_DONE`.
- `ST_DONE` raises done for one cycle and returns to `ST_IDLE`.

Top module: `trace_walk`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, the outputs mv_valid_o, done_o and rd_en_o are low.
- R2: A pointer code read from memory becomes one move in the following cycle. The pointer codes map as follows: 1 (DIAG) gives move 0 (match/mismatch), 2 (UP) gives move 2 (deletion), 3 (LEFT) gives move 1 (insertion), and 0 (END) or any other code gives move 3 (end). After an end move the walk finishes at the cell whose pointer was END.
- R3: A match move decrements both row and column, a deletion decrements the row, and an insertion decrements the column. A pointer read is issued only when both coordinates are nonzero, and its address is the current cell.
- R4: The pointer memory has one cycle of read latency. A read is issued in one cycle, and the move built from its data appears in the next cycle. Each interior step therefore takes two cycles.
- R5: Global strategy (code 0): at row 0 the walker emits insertions, and at column 0 it emits deletions, one per cycle and without memory reads, until it reaches (0,0). It then finishes there.
- R6: Local strategy (code 1) finishes as soon as the current row or column is 0, without emitting a move.
- R7: Semi-global strategy (code 2) finishes on reaching row 0. At column 0 with a nonzero row, it emits deletions, one per cycle, until it reaches row 0.
- R8: Overlap strategy (code 3) finishes as soon as the current row or column is 0, without emitting a move.
- R9: The walk ends with done_o high for exactly one cycle, with no move in that cycle. During that cycle end_row_o and end_col_o hold the final cell. Done follows a border stop by one cycle and follows an end move by one cycle.
- R10: The number of moves in one walk never exceeds the start row plus the start column.
- R11: A start pulse is accepted only while idle. A pulse during a walk changes neither that walk's moves nor its final cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| start_row_i | input | ROW_W | Start cell row |
| start_col_i | input | COL_W | Start cell column |
| strat_i | input | 2 | Strategy: 0 global, 1 local, 2 semi-global, 3 overlap |
| rd_en_o | output | 1 | Pointer memory read request |
| rd_row_o | output | ROW_W | Read address row |
| rd_col_o | output | COL_W | Read address column |
| rd_ptr_i | input | 2 | Pointer data, valid one cycle after rd_en_o |
| mv_valid_o | output | 1 | A move is presented this cycle |
| mv_code_o | output | 2 | Move: 0 match, 1 insertion, 2 deletion, 3 end |
| done_o | output | 1 | One-cycle walk-finished flag |
| end_row_o | output | ROW_W | Final row, valid with done_o |
| end_col_o | output | COL_W | Final column, valid with done_o |

## Verification
The assertions assume that rd_ptr_i carries the data of the cell addressed one cycle earlier. They also assume that start coordinates fit the stored matrix. The bench meets both assumptions with a registered memory model of an 8x8 matrix and start cells no larger than 7. A behavioural reference walk, built from the requirements, predicts for each run the read addresses, the moves, the cycle in which done rises and the final cell. The bench compares these predictions against the ports on every clock. The runs cover each strategy at both borders, END pointers in mid-walk, a start at (0,0), and a start pulse issued during a walk.

// File: rtl/trace_walk_pkg.sv
package trace_walk_pkg;

    typedef enum logic [1:0] {
        PTR_STOP = 2'd0,
        PTR_DIAG = 2'd1,
        PTR_UP   = 2'd2,
        PTR_LEFT = 2'd3
    } ptr_e;

    typedef enum logic [1:0] {
        MV_MATCH = 2'd0,
        MV_INS   = 2'd1,
        MV_DEL   = 2'd2,
        MV_END   = 2'd3
    } move_e;

    typedef enum logic [1:0] {
        STRAT_GLOBAL  = 2'd0,
        STRAT_LOCAL   = 2'd1,
        STRAT_SEMI    = 2'd2,
        STRAT_OVERLAP = 2'd3
    } strat_e;

    typedef enum logic [1:0] {
        ACT_READ,
        ACT_GAP_DEL,
        ACT_GAP_INS,
        ACT_STOP
    } edge_act_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_MM,
        ST_DONE
    } walk_state_e;

endpackage

// File: rtl/tw_ptr_decode.sv
module tw_ptr_decode
    import trace_walk_pkg::*;
(
    input  logic [1:0] ptr_code,
    output move_e      move,
    output logic       step_row,
    output logic       step_col,
    output logic       hit_end
);
    always_comb begin
        move     = MV_END;
        step_row = 1'b0;
        step_col = 1'b0;
        hit_end  = 1'b0;
        case (ptr_code)
            PTR_DIAG: begin
                move     = MV_MATCH;
                step_row = 1'b1;
                step_col = 1'b1;
            end
            PTR_UP: begin
                move     = MV_DEL;
                step_row = 1'b1;
            end
            PTR_LEFT: begin
                move     = MV_INS;
                step_col = 1'b1;
            end
            default: begin
                move    = MV_END;
                hit_end = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tw_edge_rule.sv
module tw_edge_rule
    import trace_walk_pkg::*;
(
    input  strat_e    strat,
    input  logic      row_zero,
    input  logic      col_zero,
    output edge_act_e act
);
    always_comb begin
        act = ACT_STOP;
        if (!row_zero && !col_zero) begin
            act = ACT_READ;
        end else begin
            unique case (strat)
                STRAT_GLOBAL: begin
                    if (row_zero && col_zero) act = ACT_STOP;
                    else if (row_zero)        act = ACT_GAP_INS;
                    else                      act = ACT_GAP_DEL;
                end
                STRAT_SEMI:    act = row_zero ? ACT_STOP : ACT_GAP_DEL;
                STRAT_LOCAL:   act = ACT_STOP;
                STRAT_OVERLAP: act = ACT_STOP;
            endcase
        end
    end
endmodule

// File: rtl/trace_walk.sv
module trace_walk
    import trace_walk_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ROW_W-1:0] start_row_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       strat_i,
    output logic             rd_en_o,
    output logic [ROW_W-1:0] rd_row_o,
    output logic [COL_W-1:0] rd_col_o,
    input  logic [1:0]       rd_ptr_i,
    output logic             mv_valid_o,
    output logic [1:0]       mv_code_o,
    output logic             done_o,
    output logic [ROW_W-1:0] end_row_o,
    output logic [COL_W-1:0] end_col_o
);
    localparam int SUM_W = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1;

    walk_state_e      state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    strat_e           strat_q;
    edge_act_e        act;
    move_e            dec_move;
    logic             dec_dr, dec_dc, dec_end;
    logic             row_step, col_step;
    logic             accept;

    tw_ptr_decode u_dec (
        .ptr_code (rd_ptr_i),
        .move     (dec_move),
        .step_row (dec_dr),
        .step_col (dec_dc),
        .hit_end  (dec_end)
    );

    tw_edge_rule u_edge (
        .strat    (strat_q),
        .row_zero (row_q == '0),
        .col_zero (col_q == '0),
        .act      (act)
    );

    assign accept = (state_q == ST_IDLE) && start_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_LOOK;
            ST_LOOK: begin
                if (act == ACT_READ)      state_d = ST_MM;
                else if (act == ACT_STOP) state_d = ST_DONE;
            end
            ST_MM:   state_d = dec_end ? ST_DONE : ST_LOOK;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // outputs and coordinate steps
    always_comb begin
        rd_en_o    = 1'b0;
        mv_valid_o = 1'b0;
        mv_code_o  = MV_MATCH;
        done_o     = 1'b0;
        row_step   = 1'b0;
        col_step   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOOK: begin
                unique case (act)
                    ACT_READ: rd_en_o = 1'b1;
                    ACT_GAP_DEL: begin
                        mv_valid_o = 1'b1;
                        mv_code_o  = MV_DEL;
                        row_step   = 1'b1;
                    end
                    ACT_GAP_INS: begin
                        mv_valid_o = 1'b1;
                        mv_code_o  = MV_INS;
                        col_step   = 1'b1;
                    end
                    ACT_STOP: ;
                endcase
            end
            ST_MM: begin
                mv_valid_o = 1'b1;
                mv_code_o  = dec_move;
                row_step   = dec_dr;
                col_step   = dec_dc;
            end
            ST_DONE: done_o = 1'b1;
        endcase
    end

    // cursor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q   <= '0;
            col_q   <= '0;
            strat_q <= STRAT_GLOBAL;
        end else if (accept) begin
            row_q   <= start_row_i;
            col_q   <= start_col_i;
            strat_q <= strat_e'(strat_i);
        end else begin
            row_q <= row_q - ROW_W'(row_step);
            col_q <= col_q - COL_W'(col_step);
        end
    end

    assign rd_row_o  = row_q;
    assign rd_col_o  = col_q;
    assign end_row_o = row_q;
    assign end_col_o = col_q;

    // move budget tracking for the length check
    logic [SUM_W-1:0] budget_q, mv_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            budget_q <= '0;
            mv_cnt_q <= '0;
        end else if (accept) begin
            budget_q <= SUM_W'(start_row_i) + SUM_W'(start_col_i);
            mv_cnt_q <= '0;
        end else if (mv_valid_o) begin
            mv_cnt_q <= mv_cnt_q + SUM_W'(1);
        end
    end

    // R10
    move_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_cnt_q <= budget_q);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mv_valid_o && !rd_en_o);

    // R3
    read_interior_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_row_o != '0) && (rd_col_o != '0));

    // R4
    read_then_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> mv_valid_o);

    // R2
    end_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid_o && mv_code_o == MV_END) |=> done_o);

    // R3
    diag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid_o && mv_code_o == MV_MATCH) |=>
            (row_q == $past(row_q) - ROW_W'(1)) && (col_q == $past(col_q) - COL_W'(1)));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !mv_valid_o) |=> $stable(row_q) && $stable(col_q));

endmodule

// File: tb/trace_walk_bench.sv
module trace_walk_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] srow = '0, scol = '0;
    logic [1:0] strat = '0;
    logic       rd_en, mv_valid, done;
    logic [7:0] rd_row, rd_col, end_row, end_col;
    logic [1:0] rd_ptr = '0, mv_code;

    logic [1:0] pmem [64];
    int checks = 0, errors = 0;
    int exp_mv[$], exp_rd[$];
    int exp_cyc, exp_fr, exp_fc;

    always #2 clk = ~clk;

    trace_walk u_trace_walk (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_row_i(srow),
        .start_col_i(scol), .strat_i(strat), .rd_en_o(rd_en), .rd_row_o(rd_row),
        .rd_col_o(rd_col), .rd_ptr_i(rd_ptr), .mv_valid_o(mv_valid),
        .mv_code_o(mv_code), .done_o(done), .end_row_o(end_row), .end_col_o(end_col)
    );

    always @(posedge clk) if (rd_en) rd_ptr <= pmem[{rd_row[2:0], rd_col[2:0]}];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int v);
        for (int i = 0; i < 64; i++) pmem[i] = 2'(v);
    endtask

    // behavioural reference walk
    task automatic model(input int r0, input int c0, input int s);
        int r, c, n, p;
        r = r0; c = c0; n = 0;
        exp_mv.delete(); exp_rd.delete();
        while (1) begin
            if (r > 0 && c > 0) begin
                exp_rd.push_back(r * 256 + c);
                n += 2;
                p = pmem[r * 8 + c];
                if (p == 1)      begin exp_mv.push_back(0); r--; c--; end
                else if (p == 2) begin exp_mv.push_back(2); r--; end
                else if (p == 3) begin exp_mv.push_back(1); c--; end
                else begin exp_mv.push_back(3); break; end
            end else if (s == 0 && (r > 0 || c > 0)) begin
                n++;
                if (r == 0) begin exp_mv.push_back(1); c--; end
                else        begin exp_mv.push_back(2); r--; end
            end else if (s == 2 && r > 0) begin
                n++;
                exp_mv.push_back(2); r--;
            end else begin
                n++;
                break;
            end
        end
        exp_cyc = n + 1; exp_fr = r; exp_fc = c;
    endtask

    task automatic run(input int r0, input int c0, input int s, input string tag, input bit poke);
        int cyc, moves, e;
        bit got_done, prev_rd;
        model(r0, c0, s);
        moves = 0; got_done = 0; prev_rd = 0;
        @(negedge clk);
        start = 1'b1; srow = 8'(r0); scol = 8'(c0); strat = 2'(s);
        @(negedge clk);
        start = 1'b0; srow = 8'd5; scol = 8'd1; strat = 2'd1;
        cyc = 1;
        while (!got_done && cyc < 300) begin
            if (poke && cyc == 3) start = 1'b1;
            if (poke && cyc == 4) start = 1'b0;
            if (prev_rd) chk(mv_valid, {"R4 move after read ", tag}, int'(mv_valid), 1);
            if (rd_en) begin
                if (exp_rd.size() == 0) chk(0, {"R3 extra read ", tag}, rd_row * 256 + rd_col, -1);
                else begin
                    e = exp_rd.pop_front();
                    chk(rd_row * 256 + rd_col == e, {"R3 read address ", tag}, rd_row * 256 + rd_col, e);
                end
            end
            if (mv_valid) begin
                moves++;
                if (exp_mv.size() == 0) chk(0, {"R2 extra move ", tag}, int'(mv_code), -1);
                else begin
                    e = exp_mv.pop_front();
                    chk(int'(mv_code) == e, {"R2 move code ", tag}, int'(mv_code), e);
                end
            end
            if (done) begin
                got_done = 1;
                chk(cyc == exp_cyc, {"R9 done cycle ", tag}, cyc, exp_cyc);
                chk(end_row == 8'(exp_fr), {"R9 final row ", tag}, int'(end_row), exp_fr);
                chk(end_col == 8'(exp_fc), {"R9 final col ", tag}, int'(end_col), exp_fc);
                chk(!mv_valid, {"R9 no move with done ", tag}, int'(mv_valid), 0);
                chk(exp_mv.size() == 0, {"R2 missing moves ", tag}, exp_mv.size(), 0);
            end
            prev_rd = rd_en;
            @(negedge clk);
            cyc++;
        end
        if (!got_done) chk(0, {"R9 walk never finished ", tag}, cyc, exp_cyc);
        chk(!done, {"R9 done single cycle ", tag}, int'(done), 0);
        chk(moves <= r0 + c0, {"R10 move count ", tag}, moves, r0 + c0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fill(1);
        repeat (3) @(negedge clk);
        chk(!mv_valid && !done && !rd_en, "R1 outputs in reset", int'({mv_valid, done, rd_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mv_valid && !done && !rd_en, "R1 idle after reset", int'({mv_valid, done, rd_en}), 0);

        fill(1); run(3, 3, 0, "R5 global diagonal", 0);
        fill(3); run(2, 4, 0, "R5 global column-0 deletions", 0);
        fill(2); run(3, 2, 0, "R5 global row-0 insertions", 0);
        fill(1); run(0, 0, 0, "R5 global start at origin", 0);
        fill(1); pmem[2 * 8 + 2] = 2'd0; run(4, 4, 1, "R6 local END pointer", 0);
        fill(3); run(2, 2, 1, "R6 local column 0", 0);
        fill(3); run(3, 2, 2, "R7 semi-global column-0 tail", 0);
        fill(2); run(2, 5, 2, "R7 semi-global top row", 0);
        fill(3); run(3, 2, 3, "R8 overlap column 0", 0);
        fill(2); run(2, 3, 3, "R8 overlap row 0", 0);
        fill(1); pmem[5 * 8 + 4] = 2'd2; pmem[4 * 8 + 4] = 2'd3; pmem[3 * 8 + 2] = 2'd0;
        run(6, 5, 2, "R2 mixed pointers semi-global", 0);
        fill(1); run(3, 3, 0, "R11 start ignored while busy", 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule